// File: doc/BRIEF.md
# Two-Bank Interleaved Page-Mode DRAM Controller

This block sits between a requester and a behavioural memory built from two banks of fast page-mode DRAM. Words alternate between the banks by address, and each bank remembers which row it currently has open. An access to the open row of its bank is cheap (2 cycles). An access to any other row must close the old row and open the new one (7 cycles). Both stream traffic and single scalar accesses go through the same port and follow the same latency rules.

A requester presents a word address, a write flag and write data with `req_valid`. The controller answers with `req_ready` in the same cycle. Writes are silent. Reads come back on `rsp_valid`/`rsp_data`, in the order in which they were accepted. Two kinds of request are held off with `req_ready` low: a request to a bank that is still busy, and a request whose data would come back no later than a read still pending in the other bank. Because of this, throughput depends on request order. Alternating between banks on open rows gives one access per cycle. Repeated row changes, or staying in one bank, give much less.

Top module: `dram_ilv_ctrl`

## Requirements
- R1: The bank is bit 0 of the word address. The row is word-address bits [9:8]: with 4-byte words this is the byte address above a 1 Kbyte page. Each bank keeps its own open row, so opening a row in one bank leaves the other bank's row open.
- R2: After reset `rsp_valid` is low, `req_ready` is high for any address, and no row is open in either bank.
- R3: A read accepted at clock edge E that hits its bank's open row raises `rsp_valid` for exactly one cycle, starting at edge E+2.
- R4: A read that misses its bank's open row, including the first access to each bank after reset, raises `rsp_valid` for one cycle starting at edge E+7.
- R5: An accepted access leaves its row open in its bank. A later access to that row in that bank is then a hit.
- R6: After an access, a bank takes its next access no sooner than 2 cycles later (after a hit) or 7 cycles later (after a miss). `req_ready` stays low for that bank until then.
- R7: A request is held until its data would return strictly after every read pending in the other bank. For example, a hit to one bank is accepted 6 cycles after a miss accepted by the other bank. Read responses appear in acceptance order and never two in one cycle.
- R8: A write updates the memory when it is accepted and produces no response. A later read of that address returns the written data.
- R9: A request stream that alternates banks on open rows is accepted at one request per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_data | output | 32 | Read data |

## Verification
A wrong open-row tracker cannot be seen in the data, only in timing. It turns a 2-cycle response into a 7-cycle one, or the reverse, and it moves the cycle in which `req_ready` returns. The bench therefore predicts `req_ready` and `rsp_valid` in every cycle, so such a fault shows up on the first access to the affected bank. A wrong busy count or ordering rule shows up just as quickly: `req_ready` rises a cycle early or late, or responses come back out of order or with data from the wrong address.

// File: rtl/dram_ilv_pkg.sv
package dram_ilv_pkg;

    parameter int ADDR_W     = 10;
    parameter int DATA_W     = 32;
    parameter int WORD_BYTES = 4;
    parameter int PAGE_BYTES = 1024;
    parameter int HIT_CYC    = 2;
    parameter int MISS_CYC   = 7;
    parameter int NUM_BANKS  = 2;

    localparam int PAGE_WORD_BITS = $clog2(PAGE_BYTES / WORD_BYTES);
    localparam int ROW_W          = ADDR_W - PAGE_WORD_BITS;
    localparam int COL_W          = ADDR_W - $clog2(NUM_BANKS);
    localparam int BANK_WORDS     = 1 << COL_W;
    localparam int CNT_W          = $clog2(MISS_CYC + 1);

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  write;
        col_t  col;
        row_t  row;
        word_t wdata;
    } bank_req_t;

    function automatic cnt_t access_cycles(input logic row_hit);
        return row_hit ? cnt_t'(HIT_CYC) : cnt_t'(MISS_CYC);
    endfunction

endpackage

// File: rtl/dram_ilv_rowtrk.sv
module dram_ilv_rowtrk
    import dram_ilv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic open_en,
    input  row_t row_in,
    output logic hit
);
    logic vld_q;
    row_t row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            row_q <= '0;
        end else if (open_en) begin
            vld_q <= 1'b1;
            row_q <= row_in;
        end
    end

    assign hit = vld_q && (row_q == row_in);

    // R5: an opened row is the one held afterwards
    assert_row_opened_R5: assert property (@(posedge clk) disable iff (rst)
        open_en |=> (vld_q && row_q == $past(row_in)))
        else $error("row tracker did not keep the opened row");

endmodule

// File: rtl/dram_ilv_bank.sv
module dram_ilv_bank
    import dram_ilv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      acc,
    input  bank_req_t req,
    input  cnt_t      lat,
    output cnt_t      cnt,
    output logic      rd_done,
    output word_t     rd_data
);
    word_t mem [BANK_WORDS];
    logic  pend_wr;
    col_t  pend_col;
    logic  last_cyc;

    assign last_cyc = (cnt == cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pend_wr  <= 1'b0;
            pend_col <= '0;
            rd_done  <= 1'b0;
        end else begin
            rd_done <= last_cyc && !pend_wr;
            if (acc) begin
                cnt      <= lat;
                pend_wr  <= req.write;
                pend_col <= req.col;
            end else if (cnt != '0) begin
                cnt <= cnt - cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (last_cyc)
            rd_data <= mem[pend_col];
        if (acc && req.write)
            mem[req.col] <= req.wdata;
    end

    // R6: a bank only takes work in its final busy cycle or when idle
    assert_accept_when_free_R6: assert property (@(posedge clk) disable iff (rst)
        acc |-> (cnt <= cnt_t'(1)))
        else $error("bank accepted while busy");

    // R6: an accepted access keeps the bank busy in the next cycle
    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
        acc |=> (cnt != '0))
        else $error("bank not busy after accept");

endmodule

// File: rtl/dram_ilv_ctrl.sv
module dram_ilv_ctrl
    import dram_ilv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    bank_req_t            breq;
    logic                 tgt;
    logic                 oth;
    logic [NUM_BANKS-1:0] hit;
    logic [NUM_BANKS-1:0] done;
    cnt_t                 cnt   [NUM_BANKS];
    word_t                rdata [NUM_BANKS];
    cnt_t                 lat_new;
    logic                 acc;

    assign tgt         = req_addr[0];
    assign oth         = ~req_addr[0];
    assign breq.write  = req_write;
    assign breq.col    = req_addr[ADDR_W-1:1];
    assign breq.row    = req_addr[ADDR_W-1:PAGE_WORD_BITS];
    assign breq.wdata  = req_wdata;

    assign lat_new   = access_cycles(hit[tgt]);
    assign req_ready = (cnt[tgt] <= cnt_t'(1)) && (lat_new >= cnt[oth]);
    assign acc       = req_valid && req_ready;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic acc_b;
        assign acc_b = acc && (tgt == 1'(b));

        dram_ilv_rowtrk u_rowtrk (
            .clk     (clk),
            .rst     (rst),
            .open_en (acc_b),
            .row_in  (breq.row),
            .hit     (hit[b])
        );

        dram_ilv_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .acc     (acc_b),
            .req     (breq),
            .lat     (lat_new),
            .cnt     (cnt[b]),
            .rd_done (done[b]),
            .rd_data (rdata[b])
        );
    end

    assign rsp_valid = |done;
    assign rsp_data  = done[1] ? rdata[1] : rdata[0];

    // R7: completions from the two banks never collide
    assert_single_response_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done))
        else $error("two banks completed together");

endmodule

// File: tb/dram_ilv_ctrl_bench.sv
module dram_ilv_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [9:0]  req_addr;
    logic [31:0] req_wdata;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_data;

    always #10 clk = ~clk;

    dram_ilv_ctrl u_dram_ilv_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    string       tag     = "R2";
    logic [31:0] mem_m [1024];
    int          cnt_m [2];
    int          open_m [2];
    bit          pw_m [2];
    int          pa_m [2];
    bit          exp_v;
    logic [31:0] exp_d;
    int          acc_q [$];
    int          cyc = 0;
    int          last_lat;
    int          last_acc_cyc;
    bit          last_acc;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        int b, row, lat;
        bit rdy, acc, nv;
        logic [31:0] nd;
        #1;
        b   = int'(req_addr[0]);
        row = int'(req_addr) >> 8;
        lat = (open_m[b] == row) ? 2 : 7;
        rdy = (cnt_m[b] <= 1) && (lat >= cnt_m[1-b]);
        check(req_ready === rdy, tag, "req_ready", longint'(req_ready), longint'(rdy));
        check(rsp_valid === exp_v, tag, "rsp_valid", longint'(rsp_valid), longint'(exp_v));
        if (exp_v)
            check(rsp_data === exp_d, tag, "rsp_data", longint'(rsp_data), longint'(exp_d));
        if (rsp_valid && acc_q.size() > 0)
            last_lat = cyc - acc_q.pop_front() - 1;
        acc = req_valid && rdy;
        nv = 1'b0;
        nd = '0;
        for (int bb = 0; bb < 2; bb++) begin
            if (cnt_m[bb] == 1 && !pw_m[bb]) begin
                nv = 1'b1;
                nd = mem_m[pa_m[bb]];
            end
            if (acc && bb == b) begin
                cnt_m[bb]  = lat;
                pw_m[bb]   = req_write;
                pa_m[bb]   = int'(req_addr);
                open_m[bb] = row;
            end else if (cnt_m[bb] > 0) begin
                cnt_m[bb]--;
            end
        end
        if (acc && req_write) mem_m[req_addr] = req_wdata;
        if (acc && !req_write) acc_q.push_back(cyc);
        exp_v = nv;
        exp_d = nd;
        last_acc = acc;
        if (acc) last_acc_cyc = cyc;
        cyc++;
        @(negedge clk);
    endtask

    task automatic issue(input bit wr, input int addr, input logic [31:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 10'(addr);
        req_wdata = d;
        step();
        while (!last_acc) step();
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) step();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int first_acc, prev;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < 2; i++) begin
            cnt_m[i] = 0; open_m[i] = -1; pw_m[i] = 1'b1; pa_m[i] = 0;
        end
        exp_v = 1'b0; exp_d = '0; last_lat = -1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state, ready for any address, no response
        tag = "R2";
        req_addr = 10'h155;
        step();
        check(rsp_valid == 1'b0, "R2", "rsp_valid after reset", longint'(rsp_valid), 0);

        // R8: fill memory with a stream of writes
        tag = "R8";
        for (int i = 0; i < 1024; i++) issue(1'b1, i, $urandom);
        idle(10);

        // R4: first access after row change is a miss
        tag = "R4";
        last_lat = -1;
        issue(1'b0, 10'h004, '0);
        idle(10);
        check(last_lat == 7, "R4", "miss latency bank0", last_lat, 7);

        // R3 / R5: same row in same bank is now a hit
        tag = "R3";
        issue(1'b1, 10'h006, 32'hA5A5_1234);
        idle(10);
        last_lat = -1;
        issue(1'b0, 10'h006, '0);
        idle(10);
        check(last_lat == 2, "R3", "hit latency bank0", last_lat, 2);

        // R1 / R4: bank1 still has its own row (row 3) so row 0 there misses
        tag = "R1";
        last_lat = -1;
        issue(1'b0, 10'h005, '0);
        idle(10);
        check(last_lat == 7, "R1", "bank1 miss with its own tracker", last_lat, 7);

        // R5: opening row 2 in bank1 leaves bank0 row 0 open
        tag = "R5";
        issue(1'b0, 10'h205, '0);
        idle(10);
        last_lat = -1;
        issue(1'b0, 10'h008, '0);
        idle(10);
        check(last_lat == 2, "R5", "bank0 row kept", last_lat, 2);

        // R6: back-to-back hits in one bank are 2 cycles apart
        tag = "R6";
        issue(1'b0, 10'h00A, '0);
        prev = last_acc_cyc;
        issue(1'b0, 10'h00C, '0);
        check(last_acc_cyc - prev == 2, "R6", "same-bank hit spacing", last_acc_cyc - prev, 2);
        idle(10);
        issue(1'b0, 10'h300, '0);
        prev = last_acc_cyc;
        issue(1'b0, 10'h302, '0);
        check(last_acc_cyc - prev == 7, "R6", "same-bank miss spacing", last_acc_cyc - prev, 7);
        idle(10);

        // R7: hit to bank1 waits behind miss in bank0
        tag = "R7";
        issue(1'b0, 10'h209, '0);
        idle(10);
        issue(1'b0, 10'h104, '0);
        prev = last_acc_cyc;
        issue(1'b0, 10'h20B, '0);
        check(last_acc_cyc - prev == 6, "R7", "ordering hold", last_acc_cyc - prev, 6);
        idle(12);

        // R9: alternating open-row stream at one per cycle
        tag = "R9";
        issue(1'b0, 10'h100, '0);
        issue(1'b0, 10'h101, '0);
        idle(10);
        issue(1'b0, 10'h102, '0);
        first_acc = last_acc_cyc;
        for (int a = 10'h103; a < 10'h122; a++) issue(1'b0, a, '0);
        check(last_acc_cyc - first_acc == 31, "R9", "stream cycles", last_acc_cyc - first_acc, 31);
        idle(10);

        // R7 / R8: random mix compared every cycle
        tag = "R7";
        for (int i = 0; i < 600; i++) begin
            req_valid = 1'($urandom_range(0, 3) != 0);
            req_write = 1'($urandom_range(0, 2) == 0);
            req_addr  = 10'({$urandom_range(0, 3), 6'd0} | $urandom_range(0, 7));
            req_wdata = $urandom;
            step();
        end
        idle(12);
        finish_run();
    end

endmodule